// File: doc/BRIEF.md
# Clock-Low Timeout Watchdog for an I2C Master

This block runs beside an I2C master. It measures how long the master has been waiting for the clock line to rise. A slave that holds SCL low, for example by stretching the clock, would otherwise stall the master forever. The block counts whole bit periods while SCL is low. It compares that count with an 8-bit programmed limit. When the wait reaches the limit plus one bit periods, it raises a sticky interrupt flag.

The count returns to zero whenever the master asks for a new start condition and whenever SCL falls. Each clock-low phase is therefore timed on its own. The count pauses while SCL is high. It stops once it has expired, so each low phase can raise the flag only once.

A limit of zero turns the monitor off. While the master-mode enable is low the monitor is also off: it neither counts nor flags. The SCL input is asynchronous and passes through a two-stage synchronizer before use. Software clears the flag with a one-cycle pulse.

Top module: `scl_timeout_mon`

## Requirements
- R1: After reset, `timeout_irq` is 0.
- R2: When `to_limit` is 0, `timeout_irq` never goes from 0 to 1, whatever the other inputs do.
- R3: When `master_mode` is 0, `timeout_irq` never goes from 0 to 1, and no count is kept.
- R4: With a nonzero `to_limit` of L, a run of L+1 `bit_tick` pulses seen while synchronized SCL is low raises `timeout_irq` in the cycle after the (L+1)-th pulse. No run of L pulses raises it. This holds for L = 255.
- R5: A `start_req` pulse clears the count, so counting starts again from zero.
- R6: A falling edge of SCL, detected after the two-flop synchronizer, clears the count.
- R7: `bit_tick` pulses that arrive while synchronized SCL is high are not counted.
- R8: `timeout_irq` stays at 1 until an `irq_clr` pulse. If `irq_clr` comes in the same cycle as a new expiry, the flag stays at 1.
- R9: After expiry the count holds and does not wrap. Within the same low phase no further flag is raised, however many more pulses arrive.
- R10: A new `to_limit` written during a count is used at the next pulse, without clearing the count. If the count already meets the new limit, the next low-phase pulse expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 when the I2C module acts as master |
| to_limit | input | 8 | Timeout setting; 0 disables the monitor |
| start_req | input | 1 | One-cycle pulse when a start condition is requested |
| bit_tick | input | 1 | One-cycle pulse per I2C bit period from the bit-rate generator |
| scl_in | input | 1 | Raw SCL level, asynchronous |
| irq_clr | input | 1 | One-cycle pulse that clears the flag |
| timeout_irq | output | 1 | Sticky clock-low timeout flag |

## Verification
A wrong count inside the block is only visible at `timeout_irq`. It shows up as a flag that rises one or more bit periods early or late, or one that never rises. So each check looks at the flag in the cycle after a specific pulse, and a reference model compares the flag on every clock. A restart that is lost, or a pulse that is counted while SCL is high, changes the flag within the same low phase. A counter that wraps after expiry would raise a second flag inside one long low phase. The test waits for exactly that after a clear.

// File: rtl/scl_to_pkg.sv
package scl_to_pkg;
  localparam int unsigned LIMIT_W_DEF = 8;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic low;
    logic fall;
  } scl_evt_t;
endpackage

// File: rtl/scl_to_rst_sync.sv
module scl_to_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/scl_to_sync_edge.sv
module scl_to_sync_edge
  import scl_to_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES_DEF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_raw,
  output scl_evt_t evt
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sh_q;
  logic [DEPTH-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[DEPTH-2:0], scl_raw};
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[i] <= 1'b1;
        else        sh_q[i] <= sh_d[i];
      end
    end
  endgenerate

  always_comb begin
    evt.low  = ~sh_q[STAGES-1];
    evt.fall = sh_q[STAGES] & ~sh_q[STAGES-1];
  end
endmodule

// File: rtl/scl_to_counter.sv
module scl_to_counter
  import scl_to_pkg::*;
#(
  parameter int unsigned LIMIT_W = LIMIT_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               start_req,
  input  logic               bit_tick,
  input  scl_evt_t           evt,
  output logic               expire
);
  logic [LIMIT_W-1:0] cnt_q, cnt_d;
  logic               done_q, done_d;
  logic               active, restart, step, reached;

  always_comb begin
    active  = enable & (|limit);
    restart = start_req | evt.fall;
    step    = bit_tick & evt.low & ~done_q;
    reached = (cnt_q >= limit);
    expire  = active & ~restart & step & reached;

    cnt_d  = cnt_q;
    done_d = done_q;
    if (!active || restart) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (step) begin
      if (reached) done_d = 1'b1;
      else         cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  a_r6_fall_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fall |=> (cnt_q == '0 && !done_q));

  a_r7_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !evt.low && !restart) |=> $stable(cnt_q));

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && active && !restart) |=> done_q);

  a_r3_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0 && !done_q));
endmodule

// File: rtl/scl_timeout_mon.sv
module scl_timeout_mon
  import scl_to_pkg::*;
#(
  parameter int unsigned LIMIT_W     = LIMIT_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               master_mode,
  input  logic [LIMIT_W-1:0] to_limit,
  input  logic               start_req,
  input  logic               bit_tick,
  input  logic               scl_in,
  input  logic               irq_clr,
  output logic               timeout_irq
);
  logic     rst_ns;
  scl_evt_t evt;
  logic     expire;
  logic     irq_q, irq_d;

  scl_to_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  scl_to_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_ns),
    .scl_raw (scl_in),
    .evt     (evt)
  );

  scl_to_counter #(.LIMIT_W(LIMIT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_ns),
    .enable    (master_mode),
    .limit     (to_limit),
    .start_req (start_req),
    .bit_tick  (bit_tick),
    .evt       (evt),
    .expire    (expire)
  );

  always_comb begin
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (expire)  irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign timeout_irq = irq_q;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_ns |=> !timeout_irq);

  a_r2_zero_off: assert property (@(posedge clk) disable iff (!rst_ns)
    (to_limit == '0 && !timeout_irq) |=> !timeout_irq);

  a_r3_slave_off: assert property (@(posedge clk) disable iff (!rst_ns)
    (!master_mode && !timeout_irq) |=> !timeout_irq);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_ns)
    (timeout_irq && !irq_clr) |=> timeout_irq);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_ns)
    expire |=> timeout_irq);
endmodule

// File: tb/scl_timeout_mon_tb.sv
`timescale 1ns/1ps
module scl_timeout_mon_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       master_mode, start_req, bit_tick, scl_in, irq_clr;
  logic [7:0] to_limit;
  logic       timeout_irq;

  int unsigned vectors = 0;
  int unsigned fails = 0;
  bit          cmp_on = 1'b0;
  string       tag = "R1";

  // behavioural reference state
  int  m_cnt, m_hist1, m_hist2, m_hist3;
  bit  m_done, m_flag;

  always #4 clk = ~clk;

  scl_timeout_mon u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .to_limit    (to_limit),
    .start_req   (start_req),
    .bit_tick    (bit_tick),
    .scl_in      (scl_in),
    .irq_clr     (irq_clr),
    .timeout_irq (timeout_irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_flag = 0;
      m_hist1 = 1; m_hist2 = 1; m_hist3 = 1;
    end else begin
      bit low, fall, on, rs, fire;
      low  = (m_hist2 == 0);
      fall = (m_hist3 == 1) && (m_hist2 == 0);
      on   = master_mode && (to_limit != 0);
      rs   = start_req || fall;
      fire = 0;
      if (!on || rs) begin
        m_cnt = 0; m_done = 0;
      end else if (bit_tick && low && !m_done) begin
        if (m_cnt + 1 >= int'(to_limit) + 1) begin
          fire = 1; m_done = 1;
        end else m_cnt = m_cnt + 1;
      end
      if (irq_clr) m_flag = 0;
      if (fire)    m_flag = 1;
      m_hist3 = m_hist2; m_hist2 = m_hist1; m_hist1 = int'(scl_in);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      vectors++;
      if (timeout_irq !== m_flag) begin
        fails++;
        $display("FAIL %s model compare: actual %0b expected %0b at %0t",
                 tag, timeout_irq, m_flag, $time);
      end
    end
  end

  task automatic chk(input string req, input bit exp);
    vectors++;
    if (timeout_irq !== exp) begin
      fails++;
      $display("FAIL %s: timeout_irq actual %0b expected %0b", req, timeout_irq, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; @(negedge clk);
      bit_tick = 1'b0; idle(3);
    end
  endtask

  task automatic pulse_start();
    start_req = 1'b1; @(negedge clk); start_req = 1'b0; idle(1);
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; idle(1);
  endtask

  task automatic scl_set(input bit v);
    scl_in = v; idle(4);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; master_mode = 0; to_limit = 0; start_req = 0;
    bit_tick = 0; scl_in = 1; irq_clr = 0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    cmp_on = 1'b1;
    chk("R1", 1'b0);

    master_mode = 1; to_limit = 8'd3;
    tag = "R4";
    scl_set(0); pulse_start();
    ticks(3); chk("R4", 1'b0);
    ticks(1); chk("R4", 1'b1);

    tag = "R9";
    pulse_clr(); chk("R8", 1'b0);
    ticks(6); chk("R9", 1'b0);

    tag = "R8";
    scl_set(1); scl_set(0);
    ticks(4); chk("R8", 1'b1);
    scl_set(1); scl_set(0);
    ticks(3);
    bit_tick = 1; irq_clr = 1; @(negedge clk);
    bit_tick = 0; irq_clr = 0; idle(3);
    chk("R8", 1'b1);
    pulse_clr(); chk("R8", 1'b0);

    tag = "R7";
    scl_set(1); pulse_start();
    ticks(10); chk("R7", 1'b0);
    scl_set(0);
    ticks(3); chk("R7", 1'b0);
    ticks(1); chk("R7", 1'b1);
    pulse_clr();

    tag = "R5";
    pulse_start();
    ticks(3); chk("R5", 1'b0);
    ticks(1); chk("R5", 1'b1);
    pulse_clr();

    tag = "R6";
    pulse_start(); ticks(2);
    scl_set(1); scl_set(0);
    ticks(3); chk("R6", 1'b0);
    ticks(1); chk("R6", 1'b1);
    pulse_clr();

    tag = "R10";
    to_limit = 8'd10; pulse_start();
    ticks(5); chk("R10", 1'b0);
    to_limit = 8'd2;
    ticks(1); chk("R10", 1'b1);
    pulse_clr();

    tag = "R2";
    to_limit = 8'd0; pulse_start();
    ticks(20); chk("R2", 1'b0);

    tag = "R3";
    to_limit = 8'd3; master_mode = 0; pulse_start();
    ticks(20); chk("R3", 1'b0);
    master_mode = 1;

    tag = "R4";
    to_limit = 8'd255; pulse_start();
    ticks(255); chk("R4", 1'b0);
    ticks(1); chk("R4", 1'b1);
    pulse_clr(); chk("R8", 1'b0);

    cmp_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule